// File: doc/BRIEF.md
# Packed SIMD Integer Divide and Remainder Unit

This unit divides a 128-bit packed vector by another 128-bit packed vector, lane by lane. Each lane of the dividend vector J is divided by the lane in the same position of the divisor vector K. The result of each lane goes to the same position of a 128-bit result. An operation code picks the element width (8, 16, 32 or 64 bits), signed or unsigned arithmetic, and whether the quotient or the remainder is returned. That gives sixteen distinct operations.

An operation is handed over with a valid/ready handshake. Every lane then runs a restoring division in parallel, producing one quotient bit per clock. When the finalize step ends, the whole 128-bit result appears together with a one-cycle done pulse. No operation ever traps. A zero divisor and the signed overflow case (the most negative value divided by minus one) each yield a fixed value in the affected lane. The other lanes are not affected.

Top module: `simd_divrem`

## Requirements
- R1: `in_ready` is high when the unit is idle. An operation is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low from the edge after acceptance until the operation completes.
- R2: `out_done` goes high exactly LW+2 clock edges after the accepting edge, where LW is the lane width in bits. That is one setup cycle, LW iteration cycles and one finalize cycle.
- R3: `out_done` is high for exactly one cycle per operation. `in_ready` is high in that same cycle, so a new operation can be accepted at once.
- R4: With `op_signed`=0, each lane returns the unsigned quotient (`op_rem`=0) or the unsigned remainder (`op_rem`=1) of J divided by K.
- R5: With `op_signed`=1, the lanes are two's complement values. The quotient is truncated toward zero, and a nonzero remainder has the sign of the dividend.
- R6: A lane whose divisor is zero returns 0, for all four combinations of signed/unsigned and quotient/remainder.
- R7: In signed mode, a lane with the most negative dividend (only the top bit set) and a divisor of all ones (minus one) returns the dividend itself as the quotient and 0 as the remainder.
- R8: `op_width` selects the lane width as 00=8, 01=16, 10=32 and 11=64 bits. Lane i occupies bits [i*LW +: LW] of J, K and the result. No lane's result depends on any other lane's operands.
- R9: After reset, `out_done` is 0, `in_ready` is 1 and `out_result` is 0. `out_result` keeps its value until the next operation completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The unit is idle and can accept an operation |
| op_width | input | 2 | Lane width: 00=8, 01=16, 10=32, 11=64 bits |
| op_signed | input | 1 | 1 = two's complement lanes, 0 = unsigned lanes |
| op_rem | input | 1 | 1 = return the remainder, 0 = return the quotient |
| opj | input | 128 | Dividend vector |
| opk | input | 128 | Divisor vector |
| out_done | output | 1 | One-cycle pulse when `out_result` is updated |
| out_result | output | 128 | Packed result vector, held between operations |

## Verification
Directed vectors broadcast a single value to every lane at each width. A bad lane slice or a wrong width decode then shows up as a wrong value in every lane. Sign-mixed operands in both quotient and remainder mode separate truncation toward zero from floor division, and they also catch a remainder that takes the sign of the divisor. Vectors with zero divisors or the overflow pair in alternating lanes only check that the special cases override their own lane and leave their neighbours alone. Several hundred random operations, drawn both from small divisors and from full-width divisors, exercise the normal restoring path across the whole range of operands.

// File: rtl/simd_div_pkg.sv
package simd_div_pkg;

   localparam int WSEL_W = 2;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SETUP = 2'd1,
      ST_ITER  = 2'd2,
      ST_FIN   = 2'd3
   } div_state_e;

   typedef struct packed {
      logic [WSEL_W-1:0] wsel;
      logic              sgn;
      logic              rem;
   } div_op_t;

endpackage

// File: rtl/simd_div_lane.sv
module simd_div_lane #(
   parameter int LW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          step,
   input  logic          sgn,
   input  logic          rem_sel,
   input  logic [LW-1:0] a,
   input  logic [LW-1:0] b,
   output logic [LW-1:0] res
);

   localparam logic [LW-1:0] MOST_NEG = {1'b1, {(LW-1){1'b0}}};
   localparam logic [LW-1:0] ALL_ONES = {LW{1'b1}};

   generate
      if (LW < 2) begin : g_bad_lw
         $error("simd_div_lane: LW must be at least 2");
      end
   endgenerate

   logic [LW-1:0] quo_q, rmd_q, dvs_q;
   logic          a_neg_q, b_neg_q, b_zero_q, ovf_q;
   logic          a_neg, b_neg;
   logic [LW:0]   shifted, trial;
   logic [LW-1:0] quo_fix, rmd_fix, normal;

   assign a_neg   = sgn & a[LW-1];
   assign b_neg   = sgn & b[LW-1];
   assign shifted = {rmd_q, quo_q[LW-1]};
   assign trial   = shifted - {1'b0, dvs_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quo_q    <= '0;
         rmd_q    <= '0;
         dvs_q    <= '0;
         a_neg_q  <= 1'b0;
         b_neg_q  <= 1'b0;
         b_zero_q <= 1'b1;
         ovf_q    <= 1'b0;
      end else if (load) begin
         quo_q    <= a_neg ? (~a + 1'b1) : a;
         dvs_q    <= b_neg ? (~b + 1'b1) : b;
         rmd_q    <= '0;
         a_neg_q  <= a_neg;
         b_neg_q  <= b_neg;
         b_zero_q <= (b == '0);
         ovf_q    <= sgn && (a == MOST_NEG) && (b == ALL_ONES);
      end else if (step) begin
         if (!trial[LW]) begin
            rmd_q <= trial[LW-1:0];
            quo_q <= {quo_q[LW-2:0], 1'b1};
         end else begin
            rmd_q <= shifted[LW-1:0];
            quo_q <= {quo_q[LW-2:0], 1'b0};
         end
      end
   end

   // finalize: restore signs, then let the special cases win
   assign quo_fix = (a_neg_q ^ b_neg_q) ? (~quo_q + 1'b1) : quo_q;
   assign rmd_fix = a_neg_q ? (~rmd_q + 1'b1) : rmd_q;
   assign normal  = rem_sel ? rmd_fix : quo_fix;

   always_comb begin
      if (b_zero_q)   res = '0;
      else if (ovf_q) res = rem_sel ? '0 : MOST_NEG;
      else            res = normal;
   end

   AST_REM_BELOW_DIV: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !b_zero_q) |=> (rmd_q < dvs_q)); // R4

endmodule

// File: rtl/simd_div_ctl.sv
module simd_div_ctl
   import simd_div_pkg::*;
#(
   parameter int MIN_LW = 8,
   parameter int CNT_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [WSEL_W-1:0] op_width,
   input  logic              op_signed,
   input  logic              op_rem,
   output logic              accept,
   output logic              load,
   output logic              step,
   output logic              fin,
   output logic              done,
   output div_op_t           op_cur
);

   div_state_e       state_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W:0]   lw_cur;

   assign in_ready = (state_q == ST_IDLE);
   assign accept   = in_valid & in_ready;
   assign load     = (state_q == ST_SETUP);
   assign step     = (state_q == ST_ITER);
   assign fin      = (state_q == ST_FIN);
   assign lw_cur   = (CNT_W+1)'(MIN_LW) << op_cur.wsel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         op_cur  <= '0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state_q)
            ST_IDLE: if (accept) begin
               op_cur  <= '{wsel: op_width, sgn: op_signed, rem: op_rem};
               state_q <= ST_SETUP;
            end
            ST_SETUP: begin
               cnt_q   <= '0;
               state_q <= ST_ITER;
            end
            ST_ITER: begin
               cnt_q <= cnt_q + 1'b1;
               if ({1'b0, cnt_q} == lw_cur - 1'b1) state_q <= ST_FIN;
            end
            ST_FIN: begin
               done    <= 1'b1;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // cycle counter for the latency check, counted from the accepting edge
   logic [CNT_W+1:0] lat_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   lat_q <= '0;
      else if (accept)              lat_q <= '0;
      else if (state_q != ST_IDLE)  lat_q <= lat_q + 1'b1;
   end

   AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (lat_q == {1'b0, lw_cur} + 2'd2)); // R2
   AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !in_ready); // R1
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R3
   AST_DONE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> in_ready); // R3

endmodule

// File: rtl/simd_divrem.sv
module simd_divrem
   import simd_div_pkg::*;
#(
   parameter int VEC_W  = 128,
   parameter int MIN_LW = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [WSEL_W-1:0] op_width,
   input  logic              op_signed,
   input  logic              op_rem,
   input  logic [VEC_W-1:0]  opj,
   input  logic [VEC_W-1:0]  opk,
   output logic              out_done,
   output logic [VEC_W-1:0]  out_result
);

   localparam int NUM_W  = 1 << WSEL_W;
   localparam int MAX_LW = MIN_LW << (NUM_W - 1);
   localparam int CNT_W  = $clog2(MAX_LW);

   generate
      if ((VEC_W % MAX_LW) != 0) begin : g_bad_vec
         $error("simd_divrem: VEC_W must be a multiple of the widest lane");
      end
      if (MIN_LW < 2) begin : g_bad_min
         $error("simd_divrem: MIN_LW must be at least 2");
      end
   endgenerate

   logic    accept, load, step, fin;
   div_op_t op_cur;

   simd_div_ctl #(
      .MIN_LW(MIN_LW),
      .CNT_W (CNT_W)
   ) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_ready (in_ready),
      .op_width (op_width),
      .op_signed(op_signed),
      .op_rem   (op_rem),
      .accept   (accept),
      .load     (load),
      .step     (step),
      .fin      (fin),
      .done     (out_done),
      .op_cur   (op_cur)
   );

   logic [VEC_W-1:0] j_q, k_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         j_q <= '0;
         k_q <= '0;
      end else if (accept) begin
         j_q <= opj;
         k_q <= opk;
      end
   end

   logic [VEC_W-1:0] res_by_w [NUM_W];

   generate
      for (genvar gw = 0; gw < NUM_W; gw++) begin : g_width
         localparam int LW = MIN_LW << gw;
         localparam int NL = VEC_W / LW;
         logic             sel_w;
         logic [VEC_W-1:0] res_v;
         assign sel_w = (op_cur.wsel == WSEL_W'(gw));
         for (genvar gl = 0; gl < NL; gl++) begin : g_lane
            simd_div_lane #(.LW(LW)) u_lane (
               .clk    (clk),
               .rst_n  (rst_n),
               .load   (load & sel_w),
               .step   (step & sel_w),
               .sgn    (op_cur.sgn),
               .rem_sel(op_cur.rem),
               .a      (j_q[gl*LW +: LW]),
               .b      (k_q[gl*LW +: LW]),
               .res    (res_v[gl*LW +: LW])
            );
         end
         assign res_by_w[gw] = res_v;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   out_result <= '0;
      else if (fin) out_result <= res_by_w[op_cur.wsel];
   end

   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !out_done |-> $stable(out_result)); // R9

endmodule

// File: tb/tb_simd_divrem.sv
module tb_simd_divrem;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic [1:0]   op_width = '0;
   logic         op_signed = 1'b0;
   logic         op_rem = 1'b0;
   logic [127:0] opj = '0;
   logic [127:0] opk = '0;
   logic         out_done;
   logic [127:0] out_result;

   always #4 clk = ~clk;

   simd_divrem dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .op_width(op_width), .op_signed(op_signed), .op_rem(op_rem),
      .opj(opj), .opk(opk), .out_done(out_done), .out_result(out_result)
   );

   int n_run = 0;
   int n_fail = 0;
   int cyc = 0;
   bit finished = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   logic [127:0] exp_q [$];
   int           due_q [$];
   string        tag_q [$];
   logic [127:0] last_res = '0;
   logic         prev_done = 1'b0;

   task automatic check(input bit ok, input string req, input logic [127:0] act,
                        input logic [127:0] expv);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, expv);
      end
   endtask

   // reference arithmetic, lane by lane
   function automatic logic [127:0] model(input logic [1:0] w, input bit s, input bit r,
                                          input logic [127:0] j, input logic [127:0] k);
      int          lw = 8 << w;
      int          nl = 128 / lw;
      logic [63:0] mask = (lw == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << lw) - 64'd1);
      logic [127:0] o = '0;
      for (int i = 0; i < nl; i++) begin
         logic [63:0] ua, ub, v;
         longint      sa, sb, minv;
         ua   = 64'(j >> (i * lw)) & mask;
         ub   = 64'(k >> (i * lw)) & mask;
         sa   = longint'(ua << (64 - lw)) >>> (64 - lw);
         sb   = longint'(ub << (64 - lw)) >>> (64 - lw);
         minv = longint'(64'h8000_0000_0000_0000) >>> (64 - lw);
         if (ub == 0)                     v = '0;
         else if (!s)                     v = r ? (ua % ub) : (ua / ub);
         else if (sa == minv && sb == -1) v = r ? 64'd0 : ua;
         else                             v = r ? 64'(sa % sb) : 64'(sa / sb);
         o |= 128'(v & mask) << (i * lw);
      end
      return o;
   endfunction

   function automatic logic [127:0] rep(input logic [1:0] w, input logic [63:0] v);
      int lw = 8 << w;
      logic [63:0] mask = (lw == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << lw) - 64'd1);
      logic [127:0] o = '0;
      for (int i = 0; i < 128 / lw; i++) o |= 128'(v & mask) << (i * lw);
      return o;
   endfunction

   function automatic logic [127:0] even_lanes(input logic [1:0] w);
      int lw = 8 << w;
      logic [127:0] o = '0;
      for (int i = 0; i < 128 / lw; i += 2)
         o |= ((128'd1 << lw) - 128'd1) << (i * lw);
      return o;
   endfunction

   function automatic logic [127:0] rnd128();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   // driver: offers one operation and queues the expected result
   task automatic send(input logic [1:0] w, input bit s, input bit r,
                       input logic [127:0] j, input logic [127:0] k, input string tag);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid  = 1'b1;
      op_width  = w;
      op_signed = s;
      op_rem    = r;
      opj       = j;
      opk       = k;
      exp_q.push_back(model(w, s, r, j, k));
      due_q.push_back(cyc + 1 + (8 << w) + 2);
      tag_q.push_back(tag);
      @(negedge clk);
      in_valid = 1'b0;
      opj      = rnd128();
      opk      = rnd128();
      check(in_ready == 1'b0, "R1 ready low in flight", 128'(in_ready), 128'd0);
   endtask

   // monitor: pops and compares as results come out
   always @(negedge clk) begin
      if (rst_n) begin
         if (out_done) begin
            check(!prev_done, "R3 single-cycle done", 128'(prev_done), 128'd0);
            check(in_ready, "R3 ready with done", 128'(in_ready), 128'd1);
            if (exp_q.size() == 0) begin
               check(1'b0, "R2 unexpected done", 128'd1, 128'd0);
            end else begin
               logic [127:0] e;
               int           d;
               string        t;
               e = exp_q.pop_front();
               d = due_q.pop_front();
               t = tag_q.pop_front();
               check(out_result == e, t, out_result, e);
               check(cyc == d, "R2 latency", 128'(cyc), 128'(d));
               last_res = e;
            end
         end
         prev_done <= out_done;
      end
   end

   task automatic drain();
      while (exp_q.size() != 0) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(out_done == 1'b0, "R9 reset done", 128'(out_done), 128'd0);
      check(in_ready == 1'b1, "R9 reset ready", 128'(in_ready), 128'd1);
      check(out_result == '0, "R9 reset result", out_result, '0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(in_ready == 1'b1, "R1 idle ready", 128'(in_ready), 128'd1);

      // directed broadcasts, every width and mode
      for (int w = 0; w < 4; w++) begin
         send(2'(w), 1'b0, 1'b0, rep(2'(w), 64'hDEAD_BEEF_CAFE_F00D), rep(2'(w), 64'd7),   "R4 R8 unsigned quotient");
         send(2'(w), 1'b0, 1'b1, rep(2'(w), 64'hDEAD_BEEF_CAFE_F00D), rep(2'(w), 64'd7),   "R4 R8 unsigned remainder");
         send(2'(w), 1'b1, 1'b0, rep(2'(w), -64'sd100),               rep(2'(w), 64'd7),   "R5 signed quotient neg/pos");
         send(2'(w), 1'b1, 1'b1, rep(2'(w), -64'sd100),               rep(2'(w), 64'd7),   "R5 signed remainder neg/pos");
         send(2'(w), 1'b1, 1'b0, rep(2'(w), 64'd100),                 rep(2'(w), -64'sd7), "R5 signed quotient pos/neg");
         send(2'(w), 1'b1, 1'b1, rep(2'(w), 64'd100),                 rep(2'(w), -64'sd7), "R5 signed remainder pos/neg");
         for (int m = 0; m < 4; m++)
            send(2'(w), m[1], m[0], rnd128(), '0, "R6 zero divisor all lanes");
         send(2'(w), 1'b1, 1'b0, rep(2'(w), 64'h8000_0000_0000_0000 >> (64 - (8 << w))),
              rep(2'(w), 64'hFFFF_FFFF_FFFF_FFFF), "R7 overflow quotient");
         send(2'(w), 1'b1, 1'b1, rep(2'(w), 64'h8000_0000_0000_0000 >> (64 - (8 << w))),
              rep(2'(w), 64'hFFFF_FFFF_FFFF_FFFF), "R7 overflow remainder");
         // special cases in alternate lanes only
         send(2'(w), 1'b0, 1'b0, rnd128(), rnd128() & ~even_lanes(2'(w)) | (even_lanes(2'(w)) & '0),
              "R8 zero divisor even lanes");
         send(2'(w), 1'b1, 1'b0,
              (rep(2'(w), 64'h8000_0000_0000_0000 >> (64 - (8 << w))) & even_lanes(2'(w))) | (rnd128() & ~even_lanes(2'(w))),
              (rep(2'(w), 64'hFFFF_FFFF_FFFF_FFFF) & even_lanes(2'(w))) | (rep(2'(w), 64'd3) & ~even_lanes(2'(w))),
              "R8 overflow even lanes");
      end

      // random operations, small and full-width divisors
      for (int n = 0; n < 300; n++) begin
         logic [1:0]   w;
         logic [127:0] k;
         w = 2'($urandom_range(0, 3));
         k = (n % 2 == 0) ? (rnd128() & rep(w, 64'h0F)) : rnd128();
         send(w, 1'($urandom), 1'($urandom), rnd128(), k, "R4 R5 R6 random");
      end

      drain();
      repeat (10) @(negedge clk);
      check(out_result == last_res, "R9 result held", out_result, last_res);
      check(out_done == 1'b0, "R3 no done when idle", 128'(out_done), 128'd0);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule